// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block generates one pulse-width modulated output. Software reaches it through a small register bus with a write strobe, a read strobe, an address, write data and read data. Duty values are written into a four-word queue. The modulator takes one value from the queue at the start of every output period. When the queue is empty, it keeps using the value it already holds. The period length and a clock prescaler are both programmable. A peripheral clock enable lets the surrounding logic pause the whole time base.

Each period opens with the output high. The output stays high while the period counter is below the active duty value and is low for the rest of the period. A period lasts the programmed period value plus two prescaled counts. A status word reports how full the queue is and whether a duty value was lost to a full queue. A software reset request empties the queue and clears the block. It holds the output low for a fixed four cycles, and the request bit then clears itself.

Top module: `fifo_pwm`

## Requirements
- R1: After reset every register reads zero. Address 0x00 is the control word. Its fields are run enable at bit 0, reset request at bit 3, prescaler-minus-one at [15:4], a stored clock-select at [17:16] and three stored low-power run enables at [24:22]; every other bit reads zero. Address 0x10 holds a 16-bit period value.
- R2: A write to address 0x0C puts its low 16 bits into a four-deep queue. Address 0x04 reports the queue occupancy (0 to 4) in bits [2:0], and 4 means full.
- R3: A duty write while the queue is full is dropped and sets a sticky error flag at status bit 4. Writing 1 to that bit clears the flag. Writing 0 leaves it set.
- R4: While enabled, one output period lasts (period value + 2) × (prescaler field + 1) clocks.
- R5: Each period starts high. It stays high for S × (prescaler field + 1) clocks, where S is the active duty value, and is low for the rest of the period. S = 0 keeps the output low for the whole period. S ≥ period + 2 keeps it high for the whole period.
- R6: At each period start, the head of the queue becomes the active duty value if the queue holds one. If the queue is empty, the previous value is reused.
- R7: While the block runs with a full queue, one slot frees up only at the next period boundary. Consecutive frees are one full period apart.
- R8: Writing control with bit 3 set starts a software reset. The queue empties and every other register returns to zero. The output is low throughout. Bit 3 reads 1 for exactly 4 cycles and then 0. Register writes during those cycles are ignored.
- R9: Clearing the run enable drives the output low by the second clock edge after the write. Re-enabling starts a fresh period from count zero.
- R10: While the clock enable input is low, the prescaler and period counter hold and the output does not change.
- R11: Reading address 0x0C returns the active duty value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Peripheral clock enable; pauses the time base when low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 5 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, zero when rdEn is low |
| pwmOut | output | 1 | Modulated output |

## Verification
The modulator is run with four patterns, and each waveform is compared clock by clock against a model of the period and duty rules.

- An undivided short period fed with a mixed queue (a mid value, a larger value, zero, and a value above the period) separates the normal compare from the all-low and all-high limits.
- A divided clock with a queue shorter than the number of periods shows that the prescaler stretches both phases and that the last value is reused.
- A disable-then-enable sequence shows that each run restarts from count zero.
- A full queue watched while running pins the free-slot spacing to one exact period.

Pausing the clock enable mid-pulse checks the hold behaviour. Reading registers cycle by cycle during a software reset checks its length and that writes are blocked.

// File: rtl/fifo_pwm_pkg.sv
package fifo_pwm_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 32;
  localparam int SAMPLE_W   = 16;
  localparam int PERIOD_W   = 16;
  localparam int PRESC_W    = 12;
  localparam int CNT_W      = PERIOD_W + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h10;

  localparam int RUN_BIT    = 0;
  localparam int SWR_BIT    = 3;
  localparam int PRESC_LSB  = 4;
  localparam int CSEL_LSB   = 16;
  localparam int LP_LSB     = 22;
  localparam int ERR_BIT    = 4;

  // strobes from the register side to the modulator datapath
  typedef struct packed {
    logic                push;
    logic                flush;
    logic [SAMPLE_W-1:0] data;
  } dpStrobeT;
endpackage

// File: rtl/fifo_pwm_fifo.sv
module fifo_pwm_fifo
  import fifo_pwm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic                push,
  input  logic                pop,
  input  logic [SAMPLE_W-1:0] pushData,
  output logic [SAMPLE_W-1:0] head,
  output logic [OCC_W-1:0]    occ
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic                doPush, doPop;

  assign doPush = push && (occ != OCC_W'(DEPTH));
  assign doPop  = pop && (occ != '0);
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      occ <= occ + 1'b1;
      else if (doPop && !doPush) occ <= occ - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mem[i] <= '0;
      else if (flush)                               mem[i] <= '0;
      else if (doPush && wrPtr == PTR_W'(i))        mem[i] <= pushData;
    end
  end
endmodule

// File: rtl/fifo_pwm_dp.sv
module fifo_pwm_dp
  import fifo_pwm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  dpStrobeT            strobe,
  input  logic                enable,
  input  logic [PRESC_W-1:0]  prescVal,
  input  logic [PERIOD_W-1:0] periodVal,
  output logic [OCC_W-1:0]    occ,
  output logic [SAMPLE_W-1:0] activeSample,
  output logic                pwmOut
);
  logic [PRESC_W-1:0]  presc;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    endVal;
  logic [SAMPLE_W-1:0] head;
  logic                running, start, wrapNow, loadNow, empty;

  assign endVal  = CNT_W'(periodVal) + CNT_W'(1);
  assign empty   = (occ == '0);
  assign start   = enable && !running && clkEn && !strobe.flush;
  assign wrapNow = running && enable && clkEn && (presc == prescVal) && (cnt == endVal);
  assign loadNow = (start || wrapNow) && !strobe.flush;

  fifo_pwm_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (strobe.flush),
    .push     (strobe.push),
    .pop      (loadNow),
    .pushData (strobe.data),
    .head     (head),
    .occ      (occ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running      <= 1'b0;
      cnt          <= '0;
      presc        <= '0;
      activeSample <= '0;
    end else if (strobe.flush) begin
      running      <= 1'b0;
      cnt          <= '0;
      presc        <= '0;
      activeSample <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      cnt     <= '0;
      presc   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      presc   <= '0;
      if (!empty) activeSample <= head;
    end else if (running && clkEn) begin
      if (presc == prescVal) begin
        presc <= '0;
        if (cnt == endVal) begin
          cnt <= '0;
          if (!empty) activeSample <= head;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  // output is a compare of registered state only
  assign pwmOut = running && (cnt < CNT_W'(activeSample));
endmodule

// File: rtl/fifo_pwm_ctrl.sv
module fifo_pwm_ctrl
  import fifo_pwm_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int SWR_W  = $clog2(SWR_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [OCC_W-1:0]    occ,
  input  logic [SAMPLE_W-1:0] activeSample,
  output dpStrobeT            strobe,
  output logic                enable,
  output logic [PRESC_W-1:0]  prescVal,
  output logic [PERIOD_W-1:0] periodVal,
  output logic                swrBusy
);
  logic [1:0]     clkSel;
  logic [2:0]     lpRun;
  logic           errFlag;
  logic [SWR_W-1:0] swrCnt;
  logic           wrOk, swrTrig, full;

  assign full    = (occ == OCC_W'(DEPTH));
  assign swrBusy = (swrCnt != '0);
  assign wrOk    = wrEn && !swrBusy;
  assign swrTrig = wrOk && (addr == OFS_CTRL) && wrData[SWR_BIT];

  always_comb begin
    strobe.push  = wrOk && (addr == OFS_SAMPLE) && !full;
    strobe.flush = swrTrig || swrBusy;
    strobe.data  = wrData[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      prescVal  <= '0;
      clkSel    <= '0;
      lpRun     <= '0;
      periodVal <= '0;
      errFlag   <= 1'b0;
      swrCnt    <= '0;
    end else if (swrTrig) begin
      enable    <= 1'b0;
      prescVal  <= '0;
      clkSel    <= '0;
      lpRun     <= '0;
      periodVal <= '0;
      errFlag   <= 1'b0;
      swrCnt    <= SWR_W'(SWR_CYCLES);
    end else begin
      if (swrBusy) swrCnt <= swrCnt - 1'b1;
      if (wrOk) begin
        unique case (addr)
          OFS_CTRL: begin
            enable   <= wrData[RUN_BIT];
            prescVal <= wrData[PRESC_LSB +: PRESC_W];
            clkSel   <= wrData[CSEL_LSB +: 2];
            lpRun    <= wrData[LP_LSB +: 3];
          end
          OFS_STAT:   if (wrData[ERR_BIT]) errFlag <= 1'b0;
          OFS_SAMPLE: if (full) errFlag <= 1'b1;
          OFS_PERIOD: periodVal <= wrData[PERIOD_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFS_CTRL: begin
          rdData[RUN_BIT]              = enable;
          rdData[SWR_BIT]              = swrBusy;
          rdData[PRESC_LSB +: PRESC_W] = prescVal;
          rdData[CSEL_LSB +: 2]        = clkSel;
          rdData[LP_LSB +: 3]          = lpRun;
        end
        OFS_STAT: begin
          rdData[OCC_W-1:0] = occ;
          rdData[ERR_BIT]   = errFlag;
        end
        OFS_SAMPLE: rdData[SAMPLE_W-1:0] = activeSample;
        OFS_PERIOD: rdData[PERIOD_W-1:0] = periodVal;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
  import fifo_pwm_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  dpStrobeT            strobe;
  logic                enable, swrBusy;
  logic [PRESC_W-1:0]  prescVal;
  logic [PERIOD_W-1:0] periodVal;
  logic [OCC_W-1:0]    occ;
  logic [SAMPLE_W-1:0] activeSample;

  fifo_pwm_ctrl #(.DEPTH(DEPTH), .SWR_CYCLES(SWR_CYCLES)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .occ          (occ),
    .activeSample (activeSample),
    .strobe       (strobe),
    .enable       (enable),
    .prescVal     (prescVal),
    .periodVal    (periodVal),
    .swrBusy      (swrBusy)
  );

  fifo_pwm_dp #(.DEPTH(DEPTH)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .clkEn        (clkEn),
    .strobe       (strobe),
    .enable       (enable),
    .prescVal     (prescVal),
    .periodVal    (periodVal),
    .occ          (occ),
    .activeSample (activeSample),
    .pwmOut       (pwmOut)
  );
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk #(
  parameter int DEPTH      = 4,
  parameter int SWR_CYCLES = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             pwmOut,
  input logic             enable,
  input logic             swrBusy,
  input logic             flush,
  input logic [OCC_W-1:0] occ
);
  logic [7:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busyLen <= '0;
    else if (swrBusy) busyLen <= busyLen + 1'b1;
    else              busyLen <= '0;
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(occ) <= DEPTH);

  // R2
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (int'(occ) <= int'($past(occ)) + 1) && (int'($past(occ)) <= int'(occ) + 1));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> occ == '0);

  // R8
  swr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    swrBusy |-> !pwmOut);

  // R8
  swr_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swrBusy) |-> int'(busyLen) == SWR_CYCLES);

  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && enable && !flush) |=> $stable(pwmOut));
endmodule

bind fifo_pwm fifo_pwm_chk #(.DEPTH(DEPTH), .SWR_CYCLES(SWR_CYCLES)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .clkEn   (clkEn),
  .pwmOut  (pwmOut),
  .enable  (enable),
  .swrBusy (swrBusy),
  .flush   (strobe.flush),
  .occ     (occ)
);

// File: tb/sim_fifo_pwm.sv
module sim_fifo_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMP = 5'h0C, A_PER = 5'h10;

  always #10 clk = ~clk;

  fifo_pwm u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  logic [15:0] qv [8];
  int          nq;
  logic        tr [64];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    #1;
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // must be called right after the enabling write returns
  task automatic runTrace(input string req, input int per, input int div, input int nPer,
                          input logic [15:0] lastInit);
    int n;
    n = nPer * (per + 2) * div;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tr[k] = pwmOut;
    end
    for (int p = 0; p < nPer; p++) begin
      int s, hiAct, bad;
      s = (p < nq) ? int'(qv[p]) : ((nq > 0) ? int'(qv[nq-1]) : int'(lastInit));
      hiAct = 0; bad = 0;
      for (int j = 0; j < (per + 2) * div; j++) begin
        logic e, a;
        e = ((j / div) < s);
        a = tr[p * (per + 2) * div + j];
        if (a) hiAct++;
        if (a !== e) bad++;
      end
      check(bad == 0, req, hiAct, ((s < per + 2) ? s : per + 2) * div);
    end
  endtask

  task automatic waitHigh();
    for (int i = 0; i < 40; i++) begin
      if (pwmOut) break;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(A_CTRL, v);  check(v == 0, "R1 ctrl reset", v, 0);
    rd(A_STAT, v);  check(v == 0, "R1 stat reset", v, 0);
    rd(A_SMP, v);   check(v == 0, "R1 sample reset", v, 0);
    rd(A_PER, v);   check(v == 0, "R1 period reset", v, 0);
    check(pwmOut == 0, "R1 output reset", pwmOut, 0);
  endtask

  task automatic tRegs();
    logic [31:0] v;
    wr(A_CTRL, 32'h81C2_ABC6);
    rd(A_CTRL, v);  check(v == 32'h01C2_ABC0, "R1 ctrl fields", v, 32'h01C2_ABC0);
    wr(A_PER, 32'h000A_BCDE);
    rd(A_PER, v);   check(v == 32'h0000_BCDE, "R1 period width", v, 32'hBCDE);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic tFifo();
    logic [31:0] v;
    logic [15:0] vals [4];
    vals = '{16'd3, 16'd5, 16'd0, 16'd8};
    for (int i = 0; i < 4; i++) begin
      wr(A_SMP, 32'(vals[i]));
      rd(A_STAT, v);
      check(v == 32'(i + 1), "R2 occupancy", v, i + 1);
    end
    wr(A_SMP, 32'd9);
    rd(A_STAT, v);  check(v == 32'h14, "R3 drop sets error", v, 32'h14);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v);  check(v == 32'h14, "R3 error sticky", v, 32'h14);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v);  check(v == 32'h04, "R3 error cleared", v, 32'h04);
    rd(A_SMP, v);   check(v == 0, "R11 nothing active yet", v, 0);
  endtask

  task automatic tTraceA();
    logic [31:0] v;
    qv[0] = 3; qv[1] = 5; qv[2] = 0; qv[3] = 8; nq = 4;
    wr(A_PER, 32'd6);
    wr(A_CTRL, 32'h1);
    runTrace("R4 R5 R6 undivided", 6, 1, 5, 16'd0);
    rd(A_STAT, v);  check(v == 0, "R6 queue drained", v, 0);
    rd(A_SMP, v);   check(v == 8, "R11 R3 active value", v, 8);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic tTraceB();
    qv[0] = 1; qv[1] = 3; nq = 2;
    wr(A_PER, 32'd2);
    wr(A_SMP, 32'd1);
    wr(A_SMP, 32'd3);
    wr(A_CTRL, 32'h21);
    runTrace("R4 R5 R6 divided", 2, 3, 3, 16'd0);
  endtask

  task automatic tDisable();
    int bad;
    waitHigh();
    wr(A_CTRL, 32'h20);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwmOut) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 output low when off", bad, 0);
    qv[0] = 2; nq = 1;
    wr(A_SMP, 32'd2);
    wr(A_CTRL, 32'h21);
    runTrace("R9 restart from zero", 2, 3, 2, 16'd3);
  endtask

  task automatic tPause();
    int bad;
    logic [31:0] v;
    logic [31:0] v2;
    waitHigh();
    check(pwmOut == 1, "R10 reached high phase", pwmOut, 1);
    rd(A_STAT, v);
    clkEn = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!pwmOut) bad++;
    end
    rd(A_STAT, v2);
    check(bad == 0, "R10 output held", bad, 0);
    check(v2 == v, "R10 status held", v2, v);
    clkEn = 1'b1;
    bad = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!pwmOut) begin bad = 0; break; end
    end
    check(bad == 0, "R10 resumes", bad, 0);
  endtask

  task automatic tFull();
    logic [31:0] v;
    int c4, c3;
    v = 0;
    for (int i = 0; i < 6; i++) begin
      wr(A_SMP, 32'd7);
      rd(A_STAT, v);
      if (v[2:0] == 3'd4) break;
    end
    check(v[2:0] == 3'd4, "R7 queue full", v[2:0], 4);
    c4 = 0;
    for (int i = 0; i < 40; i++) begin
      rd(A_STAT, v);
      if (v[2:0] != 3'd4) break;
      c4++;
      @(negedge clk);
    end
    check(c4 >= 1 && c4 <= 12 && v[2:0] == 3'd3, "R7 first free slot", c4, 12);
    c3 = 0;
    for (int i = 0; i < 40; i++) begin
      rd(A_STAT, v);
      if (v[2:0] != 3'd3) break;
      c3++;
      @(negedge clk);
    end
    check(c3 == 12, "R7 R4 free spacing", c3, 12);
  endtask

  task automatic tSwr();
    logic [31:0] v;
    wr(A_CTRL, 32'h9);
    rd(A_CTRL, v);  check(v == 32'h8, "R8 busy cycle 1", v, 8);
    check(pwmOut == 0, "R8 output low", pwmOut, 0);
    wr(A_PER, 32'h55);
    rd(A_CTRL, v);  check(v == 32'h8, "R8 busy cycle 2", v, 8);
    waitCyc(1);
    rd(A_CTRL, v);  check(v == 32'h8, "R8 busy cycle 3", v, 8);
    waitCyc(1);
    rd(A_CTRL, v);  check(v == 32'h8, "R8 busy cycle 4", v, 8);
    waitCyc(1);
    rd(A_CTRL, v);  check(v == 32'h0, "R8 self clear", v, 0);
    rd(A_PER, v);   check(v == 0, "R8 write ignored", v, 0);
    rd(A_STAT, v);  check(v == 0, "R8 queue flushed", v, 0);
    rd(A_SMP, v);   check(v == 0, "R8 active cleared", v, 0);
    check(pwmOut == 0, "R8 output after", pwmOut, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tFifo();
    tTraceA();
    tTraceB();
    tDisable();
    tPause();
    tFull();
    tSwr();
    summary();
  end
endmodule